// File: doc/BRIEF.md
# Lazy NZCV flag evaluator

This block rebuilds the four condition flags (negative, zero, carry, overflow) from a stored record of the most recent flag-setting operation. It does not watch the ALU while an operation executes. Instead, the record holds a 4-bit operation code and three 32-bit operand words. The block evaluates the record only when a consumer needs the flags, such as a conditional branch or an explicit flag read.

The caller presents a record together with a valid strobe. One clock later the block returns three things:

- a 32-bit flag word with the flags packed into its top nibble;
- separate carry and overflow bits;
- an error bit for operation codes that the block does not know.

When no strobe is given, the last result stays on the outputs. Setting the parameter `REG_OUT` to 0 selects a purely combinational variant with no latency.

Top module: `nzcv_lazy_eval`

## Requirements
- R1: While reset is high, and on the first cycle after it, `res_valid`, `flags_word` and `op_err` are all zero.
- R2: A result appears exactly one clock after a cycle with `rec_valid` high. In a cycle after one with `rec_valid` low, `res_valid` is low and every output keeps its previous value.
- R3: The flag word carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Bits 27:0 are always zero.
- R4: Operation code 0 (copy) places bits 31:28 of `rec_a` unchanged into bits 31:28 of the flag word. All other bits of the operands are ignored.
- R5: Operation code 1 (add) forms `rec_a + rec_b`. N is the result's top bit, Z is set when the 32-bit result is zero, C is the carry out of bit 31, and V is set when both operands have the same sign and the result's sign differs from theirs.
- R6: Operation code 2 (subtract) forms `rec_a - rec_b`. C is set when no borrow occurs, that is when `rec_a >= rec_b` unsigned. V is set when the operands differ in sign and the result's sign differs from that of `rec_a`.
- R7: Operation code 3 (add with carry) forms `rec_a + rec_b + rec_c[0]`. The flags follow the rules of R5.
- R8: Operation code 4 (subtract with carry) forms `rec_a - rec_b - (1 - rec_c[0])`. C means no borrow, and V is signed overflow of that difference.
- R9: Operation code 5 (logical): N and Z come from `rec_a`, C equals `rec_b[0]` and V equals `rec_c[0]`.
- R10: Operation code 6 (32-bit multiply): N and Z come from `rec_a`, C equals `rec_c[1]` and V equals `rec_c[0]`.
- R11: Operation code 7 (64-bit multiply): N equals `rec_b[31]`, and Z is set only when both `rec_b` (high half) and `rec_a` (low half) are zero. C equals `rec_c[1]` and V equals `rec_c[0]`.
- R12: Operation codes 8 to 15 give an all-zero flag word and raise `op_err`. Codes 0 to 7 leave `op_err` low.
- R13: `carry_bit` always equals bit 29 of `flags_word`, and `ovf_bit` always equals bit 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record strobe; evaluate this cycle's record |
| rec_op | input | 4 | Operation code of the record |
| rec_a | input | 32 | First operand word |
| rec_b | input | 32 | Second operand word |
| rec_c | input | 32 | Third operand word (old carry/overflow bits) |
| res_valid | output | 1 | Result presented this cycle |
| flags_word | output | 32 | N, Z, C, V in bits 31:28, zero elsewhere |
| carry_bit | output | 1 | Carry flag alone |
| ovf_bit | output | 1 | Overflow flag alone |
| op_err | output | 1 | Unknown operation code |

## Verification
Presenting the result of one record and capturing the next one can fall in the same clock edge. The bench provokes this by driving strobes on consecutive cycles with no gap, across every operation code and a stream of pseudo-random operands. It then judges that the scoreboard pops the results in strobe order, each matching its own record and not a neighbour's. Gaps with the strobe low are mixed into the stream, and the monitor checks in each gap that the last flag word is held rather than replaced.

// File: rtl/nzcv_pkg.sv
package nzcv_pkg;

    localparam int WORD_W   = 32;
    localparam int OP_W     = 4;
    localparam int FLAG_W   = 4;
    localparam int OP_COUNT = 8;

    localparam int N_POS = WORD_W - 1;
    localparam int Z_POS = WORD_W - 2;
    localparam int C_POS = WORD_W - 3;
    localparam int V_POS = WORD_W - 4;

    typedef enum logic [OP_W-1:0] {
        OP_COPY  = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_ADC   = 4'd3,
        OP_SBB   = 4'd4,
        OP_LOGIC = 4'd5,
        OP_MUL   = 4'd6,
        OP_MULL  = 4'd7
    } rec_op_e;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic word_t pack_flags(nzcv_t f);
        return {f.n, f.z, f.c, f.v, {(WORD_W-FLAG_W){1'b0}}};
    endfunction

    function automatic logic word_is_zero(word_t w);
        return ~|w;
    endfunction

    function automatic logic op_is_known(logic [OP_W-1:0] op);
        return op < OP_W'(OP_COUNT);
    endfunction

    function automatic logic op_is_arith(logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADC) || (op == OP_SBB);
    endfunction

endpackage

// File: rtl/nzcv_arith.sv
module nzcv_arith
    import nzcv_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  word_t           lhs,
    input  word_t           rhs_raw,
    input  logic            old_c,
    output nzcv_t           flags
);

    logic              is_sub;
    logic              use_old_c;
    word_t             rhs_eff;
    logic              cin;
    logic [WORD_W:0]   total;
    word_t             result;

    always_comb begin
        is_sub    = (op == OP_SUB) || (op == OP_SBB);
        use_old_c = (op == OP_ADC) || (op == OP_SBB);
        rhs_eff   = is_sub ? ~rhs_raw : rhs_raw;
        cin       = use_old_c ? old_c : is_sub;
        total     = {1'b0, lhs} + {1'b0, rhs_eff} + {{WORD_W{1'b0}}, cin};
        result    = total[WORD_W-1:0];
    end

    always_comb begin
        flags.n = result[WORD_W-1];
        flags.z = word_is_zero(result);
        flags.c = total[WORD_W];
        flags.v = (lhs[WORD_W-1] == rhs_eff[WORD_W-1]) &&
                  (result[WORD_W-1] != lhs[WORD_W-1]);
    end

endmodule

// File: rtl/nzcv_direct.sv
module nzcv_direct
    import nzcv_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  word_t           lhs,
    input  word_t           rhs,
    input  logic [1:0]      old_cv,
    output nzcv_t           flags
);

    always_comb begin
        flags = '0;
        case (op)
            OP_COPY: begin
                flags = nzcv_t'(lhs[WORD_W-1 -: FLAG_W]);
            end
            OP_LOGIC: begin
                flags.n = lhs[WORD_W-1];
                flags.z = word_is_zero(lhs);
                flags.c = rhs[0];
                flags.v = old_cv[0];
            end
            OP_MUL: begin
                flags.n = lhs[WORD_W-1];
                flags.z = word_is_zero(lhs);
                flags.c = old_cv[1];
                flags.v = old_cv[0];
            end
            OP_MULL: begin
                flags.n = rhs[WORD_W-1];
                flags.z = word_is_zero(lhs) && word_is_zero(rhs);
                flags.c = old_cv[1];
                flags.v = old_cv[0];
            end
            default: flags = '0;
        endcase
    end

endmodule

// File: rtl/nzcv_select.sv
module nzcv_select
    import nzcv_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  nzcv_t           arith_flags,
    input  nzcv_t           direct_flags,
    output word_t           word,
    output logic            c_bit,
    output logic            v_bit,
    output logic            err
);

    nzcv_t chosen;

    always_comb begin
        err = !op_is_known(op);
        if (err)
            chosen = '0;
        else if (op_is_arith(op))
            chosen = arith_flags;
        else
            chosen = direct_flags;
        word  = pack_flags(chosen);
        c_bit = chosen.c;
        v_bit = chosen.v;
    end

endmodule

// File: rtl/nzcv_lazy_eval.sv
module nzcv_lazy_eval
    import nzcv_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_valid,
    input  logic [OP_W-1:0]   rec_op,
    input  logic [WORD_W-1:0] rec_a,
    input  logic [WORD_W-1:0] rec_b,
    input  logic [WORD_W-1:0] rec_c,
    output logic              res_valid,
    output logic [WORD_W-1:0] flags_word,
    output logic              carry_bit,
    output logic              ovf_bit,
    output logic              op_err
);

    nzcv_t arith_f;
    nzcv_t direct_f;
    word_t comb_word;
    logic  comb_c;
    logic  comb_v;
    logic  comb_err;
    logic  unused_c_hi;

    assign unused_c_hi = ^rec_c[WORD_W-1:2];

    nzcv_arith u_arith (
        .op      (rec_op),
        .lhs     (rec_a),
        .rhs_raw (rec_b),
        .old_c   (rec_c[0]),
        .flags   (arith_f)
    );

    nzcv_direct u_direct (
        .op     (rec_op),
        .lhs    (rec_a),
        .rhs    (rec_b),
        .old_cv (rec_c[1:0]),
        .flags  (direct_f)
    );

    nzcv_select u_select (
        .op           (rec_op),
        .arith_flags  (arith_f),
        .direct_flags (direct_f),
        .word         (comb_word),
        .c_bit        (comb_c),
        .v_bit        (comb_v),
        .err          (comb_err)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_valid  <= 1'b0;
                    flags_word <= '0;
                    carry_bit  <= 1'b0;
                    ovf_bit    <= 1'b0;
                    op_err     <= 1'b0;
                end else begin
                    res_valid <= rec_valid;
                    if (rec_valid) begin
                        flags_word <= comb_word;
                        carry_bit  <= comb_c;
                        ovf_bit    <= comb_v;
                        op_err     <= comb_err;
                    end
                end
            end

            // R2: one-cycle latency for every strobe
            a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
                rec_valid |=> res_valid);

            // R2: idle cycles hold the last result
            a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
                !rec_valid |=> (!res_valid && $stable(flags_word) && $stable(op_err)));

            // R12: unknown codes blank the flag word
            a_r12_err_blank: assert property (@(posedge clk) disable iff (rst)
                op_err |-> (flags_word == '0));

            // R12: known codes never raise the error
            a_r12_known_clean: assert property (@(posedge clk) disable iff (rst)
                (rec_valid && (rec_op < OP_W'(OP_COUNT))) |=> !op_err);

            // R13: single-bit outputs agree with the packed word
            a_r13_bits_agree: assert property (@(posedge clk) disable iff (rst)
                (carry_bit == flags_word[C_POS]) && (ovf_bit == flags_word[V_POS]));

            // R3: low bits of the word stay clear
            a_r3_low_clear: assert property (@(posedge clk) disable iff (rst)
                res_valid |-> (flags_word[V_POS-1:0] == '0));
        end else begin : g_comb
            assign res_valid  = rec_valid;
            assign flags_word = comb_word;
            assign carry_bit  = comb_c;
            assign ovf_bit    = comb_v;
            assign op_err     = comb_err;
        end
    endgenerate

endmodule

// File: tb/nzcv_lazy_eval_bench.sv
`timescale 1ns/1ps
module nzcv_lazy_eval_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rec_valid = 1'b0;
    logic [3:0]  rec_op = '0;
    logic [31:0] rec_a = '0;
    logic [31:0] rec_b = '0;
    logic [31:0] rec_c = '0;
    logic        res_valid;
    logic [31:0] flags_word;
    logic        carry_bit;
    logic        ovf_bit;
    logic        op_err;

    always #2 clk = ~clk;

    nzcv_lazy_eval u_nzcv_lazy_eval (
        .clk        (clk),
        .rst        (rst),
        .rec_valid  (rec_valid),
        .rec_op     (rec_op),
        .rec_a      (rec_a),
        .rec_b      (rec_b),
        .rec_c      (rec_c),
        .res_valid  (res_valid),
        .flags_word (flags_word),
        .carry_bit  (carry_bit),
        .ovf_bit    (ovf_bit),
        .op_err     (op_err)
    );

    typedef struct packed {
        logic [31:0] word;
        logic        c;
        logic        v;
        logic        err;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  last_exp = '0;
    int    checks = 0;
    int    errors = 0;
    bit    running = 1'b0;
    bit    done = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    task automatic check_val(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic exp_t model(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] c);
        exp_t        e;
        logic [63:0] s;
        longint      sa;
        longint      sb;
        longint      ss;
        logic [31:0] r;
        logic        n, z, cf, vf;
        int          k;
        e  = '0;
        n  = 0; z = 0; cf = 0; vf = 0;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            4'd0: {n, z, cf, vf} = a[31:28];
            4'd1, 4'd3: begin
                k  = (op == 4'd3) ? int'(c[0]) : 0;
                s  = {32'b0, a} + {32'b0, b} + 64'(k);
                r  = s[31:0];
                n  = r[31]; z = (r == 0); cf = s[32];
                ss = sa + sb + longint'(k);
                vf = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
            end
            4'd2, 4'd4: begin
                k  = (op == 4'd4) ? int'(!c[0]) : 0;
                cf = ({32'b0, a} >= ({32'b0, b} + 64'(k)));
                r  = a - b - 32'(k);
                n  = r[31]; z = (r == 0);
                ss = sa - sb - longint'(k);
                vf = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
            end
            4'd5: begin n = a[31]; z = (a == 0); cf = b[0]; vf = c[0]; end
            4'd6: begin n = a[31]; z = (a == 0); cf = c[1]; vf = c[0]; end
            4'd7: begin n = b[31]; z = ({b, a} == 64'd0); cf = c[1]; vf = c[0]; end
            default: e.err = 1'b1;
        endcase
        e.word = {n, z, cf, vf, 28'b0};
        e.c    = cf;
        e.v    = vf;
        return e;
    endfunction

    task automatic send(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] c, string tag);
        @(negedge clk);
        rec_valid = 1'b1;
        rec_op = op; rec_a = a; rec_b = b; rec_c = c;
        exp_q.push_back(model(op, a, b, c));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rec_valid = 1'b0;
            rec_op = 4'(lcg[3:0]); rec_a = lcg; rec_b = ~lcg; rec_c = lcg;
        end
    endtask

    function automatic logic [31:0] next_rand(logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    // Monitor: pops the scoreboard when a result is presented
    always @(negedge clk) begin
        if (running && !rst) begin
            if (res_valid) begin
                exp_t  e;
                string t;
                if (exp_q.size() == 0) begin
                    check_val("R2 unexpected result", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check_val({t, "/R3 word"}, flags_word, e.word);
                    check_val("R13 carry", {31'b0, carry_bit}, {31'b0, e.c});
                    check_val("R13 ovf", {31'b0, ovf_bit}, {31'b0, e.v});
                    check_val({"R12 err ", t}, {31'b0, op_err}, {31'b0, e.err});
                    last_exp = e;
                end
            end else begin
                check_val("R2 hold word", flags_word, last_exp.word);
                check_val("R2 hold err", {31'b0, op_err}, {31'b0, last_exp.err});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        check_val("R1 valid", {31'b0, res_valid}, 32'd0);
        check_val("R1 word", flags_word, 32'd0);
        check_val("R1 err", {31'b0, op_err}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check_val("R1 valid after", {31'b0, res_valid}, 32'd0);
        running = 1'b1;

        // R4 copy ignores low bits
        send(4'd0, 32'h5123_4567, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
        send(4'd0, 32'hAFFF_FFFF, 32'd0, 32'd0, "R4");
        // R5 add
        send(4'd1, 32'h7FFF_FFFF, 32'd1, 32'hFFFF_FFFF, "R5");
        send(4'd1, 32'hFFFF_FFFF, 32'd1, 32'd0, "R5");
        send(4'd1, 32'h8000_0000, 32'h8000_0000, 32'd0, "R5");
        idle(2);
        // R6 subtract
        send(4'd2, 32'd5, 32'd5, 32'd0, "R6");
        send(4'd2, 32'd3, 32'd5, 32'd1, "R6");
        send(4'd2, 32'h8000_0000, 32'd1, 32'd0, "R6");
        // R7 add with carry
        send(4'd3, 32'hFFFF_FFFF, 32'd0, 32'd1, "R7");
        send(4'd3, 32'h7FFF_FFFF, 32'd0, 32'd1, "R7");
        send(4'd3, 32'h7FFF_FFFF, 32'd0, 32'd0, "R7");
        // R8 subtract with carry
        send(4'd4, 32'd5, 32'd5, 32'd0, "R8");
        send(4'd4, 32'd5, 32'd5, 32'd1, "R8");
        send(4'd4, 32'd0, 32'hFFFF_FFFF, 32'd0, "R8");
        send(4'd4, 32'h8000_0000, 32'd0, 32'd0, "R8");
        idle(1);
        // R9 logical
        send(4'd5, 32'd0, 32'd1, 32'd1, "R9");
        send(4'd5, 32'h8000_0000, 32'd2, 32'd0, "R9");
        // R10 multiply
        send(4'd6, 32'd0, 32'hFFFF_FFFF, 32'd2, "R10");
        send(4'd6, 32'h8000_0001, 32'd0, 32'd1, "R10");
        // R11 long multiply
        send(4'd7, 32'd1, 32'd0, 32'd3, "R11");
        send(4'd7, 32'd0, 32'd0, 32'd0, "R11");
        send(4'd7, 32'd0, 32'h8000_0000, 32'd2, "R11");
        send(4'd7, 32'hFFFF_FFFF, 32'h0000_0001, 32'd1, "R11");
        // R12 unknown codes after a result with flags set
        send(4'd1, 32'hFFFF_FFFF, 32'd1, 32'd0, "R5");
        send(4'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd3, "R12");
        send(4'd15, 32'd0, 32'd0, 32'd3, "R12");
        idle(2);
        send(4'd2, 32'd9, 32'd4, 32'd0, "R12 recovery");

        // Back-to-back stream over all codes with occasional gaps
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b, c;
            lcg = next_rand(lcg); a = lcg;
            lcg = next_rand(lcg); b = (lcg[7:0] == 8'd0) ? a : lcg;
            lcg = next_rand(lcg); c = {30'd0, lcg[17:16]};
            if (lcg[25:23] == 3'd0) a = 32'd0;
            send(4'(lcg[31:28]), a, b, c, "R3 stream");
            if (lcg[5:2] == 4'd0) idle(1);
        end
        idle(3);
        running = 1'b0;
        check_val("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule